// File: doc/BRIEF.md
# Thinned-Interrupt Free-Running Timer

The block is a 16-bit timer that runs freely against a compare value. It has two counting shapes. In the up-only shape the count climbs from zero to the compare value and then reloads to zero. In the triangle shape it climbs to the compare value and then falls back to zero, again and again. Each pass produces two kinds of event. A compare event occurs when the compare value is reached. A zero event occurs when the count lands on zero. Each event kind latches its own sticky flag, and an enable bit gates that flag onto an interrupt line.

A 3-bit skip field thins one of the two event kinds, so that only every (skip+1)-th occurrence latches the flag. In the up-only shape the compare event is thinned. In the triangle shape the zero event is thinned. The other event kind is never thinned.

The count advances on an internal tick. The tick comes either every cycle or once every 2^k cycles, chosen by a 2-bit divider select. A software-clear strobe restarts the count. Whether it also latches the zero flag depends on whether the tick is divided.

Top module: `evt_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes 0, the direction becomes upward, both flags clear and the skip counter clears.
- R2: With `run_en` high and `div_sel` = k, `count` advances once every 2^k clock cycles; the first step comes on the 2^k-th edge after reset or a software clear. With `run_en` low, `count` holds.
- R3: With `updown` = 0 and compare value C, `count` runs 0,1,…,C and then returns to 0 on the next tick. That reload is both a compare event and a zero event.
- R4: With `updown` = 1 and compare value C ≥ 1, `count` runs 0 up to C and back down to 0, repeating every 2C ticks. Arriving at C is a compare event and reverses the direction in the same step. Arriving back at 0 is a zero event and turns the count upward again.
- R5: The thinned event kind is the compare event when `updown` = 0 and the zero event when `updown` = 1. Its flag is set only on occurrences S+1, 2(S+1), … counted since the skip counter last cleared, where S = `skip_n`; S = 0 sets it on every occurrence. The other event kind sets its flag on every occurrence.
- R6: The skip counter clears on a software clear and on any clock edge at which `skip_n` differs from its value at the previous edge.
- R7: A `sw_clr` pulse sets `count` to 0, turns the direction upward and restarts the divider. It sets the zero flag when `div_sel` ≠ 0, and it leaves the zero flag unchanged when `div_sel` = 0.
- R8: A flag stays set until its ack strobe is high at a clock edge. If a new set and an ack arrive at the same edge, the set wins.
- R9: Each `irq_*` output is high exactly when its flag and its enable are both high. Flags latch whether or not the enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Counting enable |
| div_sel | input | 2 | Tick divider exponent k (0 = every cycle) |
| updown | input | 1 | 0 = up-only reload shape, 1 = up/down triangle shape |
| cmp_val | input | 16 | Compare value |
| skip_n | input | 3 | Number of thinned-event occurrences skipped between flag sets |
| sw_clr | input | 1 | Software clear strobe |
| zero_ack | input | 1 | Clears the zero flag |
| cmp_ack | input | 1 | Clears the compare flag |
| zero_ie | input | 1 | Zero interrupt enable |
| cmp_ie | input | 1 | Compare interrupt enable |
| count | output | 16 | Current count |
| zero_flag | output | 1 | Sticky zero-event flag |
| cmp_flag | output | 1 | Sticky compare-event flag |
| irq_zero | output | 1 | Zero interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |

## Verification
A wrong divider phase or a wrong direction bit shows on `count` within one tick. The bench therefore compares the whole count trajectory against a closed-form function of the elapsed ticks. A skip counter that is off by one, or that fails to clear, is invisible on `count` and shows only at the flags, one thinned event too early or too late. It is exposed by counting flag sets over long runs for every skip value, and by directed runs where the clear falls between two events. A wrong software-clear flag rule shows on the zero flag at the very next edge.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic {
        MODE_UP     = 1'b0,
        MODE_UPDOWN = 1'b1
    } mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic cmp_hit;
        logic zero_hit;
    } evt_s;

    function automatic logic thinned_is_zero(mode_e m);
        return m == MODE_UPDOWN;
    endfunction

endpackage

// File: rtl/evt_timer_presc.sv
module evt_timer_presc #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run_en,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pcnt_q;
    logic [PRE_W-1:0] phase_mask;

    // mask of the low k bits; wraps to all ones for the largest k
    always_comb begin
        phase_mask = (PRE_W'(1) << div_sel) - PRE_W'(1);
        tick       = run_en && ((pcnt_q & phase_mask) == phase_mask);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt_q <= '0;
        end else if (run_en) begin
            pcnt_q <= pcnt_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  mode_e            mode,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output evt_s             evt
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] cnt_q, cnt_d, up_nxt, dn_nxt;
    dir_e             dir_q, dir_d;

    always_comb begin
        up_nxt = (cnt_q == CNT_MAX)  ? CNT_MAX  : cnt_q + 1'b1;
        dn_nxt = (cnt_q == CNT_ZERO) ? CNT_ZERO : cnt_q - 1'b1;
        cnt_d  = cnt_q;
        dir_d  = dir_q;
        evt    = '0;
        if (tick && !restart) begin
            if (mode == MODE_UP) begin
                dir_d = DIR_UP;
                if (cnt_q >= cmp_val) begin
                    cnt_d        = CNT_ZERO;
                    evt.cmp_hit  = 1'b1;
                    evt.zero_hit = 1'b1;
                end else begin
                    cnt_d = up_nxt;
                end
            end else if (dir_q == DIR_UP) begin
                cnt_d = up_nxt;
                if (up_nxt >= cmp_val) begin
                    dir_d       = DIR_DOWN;
                    evt.cmp_hit = 1'b1;
                end
            end else begin
                cnt_d = dn_nxt;
                if (dn_nxt == CNT_ZERO) begin
                    dir_d        = DIR_UP;
                    evt.zero_hit = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= CNT_ZERO;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/evt_timer_thin.sv
module evt_timer_thin
    import evt_timer_pkg::*;
#(
    parameter int SKIP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  mode_e             mode,
    input  logic [SKIP_W-1:0] skip_n,
    input  evt_s              evt,
    input  logic              force_zero,
    input  logic              zero_ack,
    input  logic              cmp_ack,
    output logic              zero_flag,
    output logic              cmp_flag
);
    logic [SKIP_W-1:0] skip_q;
    logic [SKIP_W-1:0] seen_q;
    logic              skip_chg, sel_hit, pass, zero_set, cmp_set;
    logic              zero_q, cmp_q;

    always_comb begin
        skip_chg = (skip_n != skip_q);
        sel_hit  = thinned_is_zero(mode) ? evt.zero_hit : evt.cmp_hit;
        pass     = sel_hit && (seen_q == skip_n);
        if (thinned_is_zero(mode)) begin
            zero_set = pass || force_zero;
            cmp_set  = evt.cmp_hit;
        end else begin
            zero_set = evt.zero_hit || force_zero;
            cmp_set  = pass;
        end
    end

    always_ff @(posedge clk) begin
        skip_q <= skip_n;
        if (rst || restart || skip_chg) begin
            seen_q <= '0;
        end else if (sel_hit) begin
            seen_q <= pass ? '0 : seen_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_q <= 1'b0;
            cmp_q  <= 1'b0;
        end else begin
            if (zero_set)      zero_q <= 1'b1;
            else if (zero_ack) zero_q <= 1'b0;
            if (cmp_set)       cmp_q  <= 1'b1;
            else if (cmp_ack)  cmp_q  <= 1'b0;
        end
    end

    assign zero_flag = zero_q;
    assign cmp_flag  = cmp_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 2,
    parameter int SKIP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              updown,
    input  logic [CNT_W-1:0]  cmp_val,
    input  logic [SKIP_W-1:0] skip_n,
    input  logic              sw_clr,
    input  logic              zero_ack,
    input  logic              cmp_ack,
    input  logic              zero_ie,
    input  logic              cmp_ie,
    output logic [CNT_W-1:0]  count,
    output logic              zero_flag,
    output logic              cmp_flag,
    output logic              irq_zero,
    output logic              irq_cmp
);
    mode_e mode;
    evt_s  evt;
    logic  tick;
    logic  divided;

    assign mode    = updown ? MODE_UPDOWN : MODE_UP;
    assign divided = (div_sel != '0);

    evt_timer_presc #(.SEL_W(SEL_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (sw_clr),
        .run_en  (run_en),
        .div_sel (div_sel),
        .tick    (tick)
    );

    evt_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .restart (sw_clr),
        .tick    (tick),
        .mode    (mode),
        .cmp_val (cmp_val),
        .count   (count),
        .evt     (evt)
    );

    evt_timer_thin #(.SKIP_W(SKIP_W)) u_thin (
        .clk        (clk),
        .rst        (rst),
        .restart    (sw_clr),
        .mode       (mode),
        .skip_n     (skip_n),
        .evt        (evt),
        .force_zero (sw_clr && divided),
        .zero_ack   (zero_ack),
        .cmp_ack    (cmp_ack),
        .zero_flag  (zero_flag),
        .cmp_flag   (cmp_flag)
    );

    assign irq_zero = zero_flag && zero_ie;
    assign irq_cmp  = cmp_flag && cmp_ie;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic [SEL_W-1:0] div_sel,
    input logic             sw_clr,
    input logic             zero_ack,
    input logic             cmp_ack,
    input logic             zero_ie,
    input logic             cmp_ie,
    input logic [CNT_W-1:0] count,
    input logic             zero_flag,
    input logic             cmp_flag,
    input logic             irq_zero,
    input logic             irq_cmp
);
    // R1
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && !zero_flag && !cmp_flag));

    // R2
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !sw_clr) |=> $stable(count));

    // R3, R4: count only steps by one or returns to zero
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        run_en |=> (count == '0 || $stable(count) ||
                    count == $past(count) + 1'b1 || count == $past(count) - 1'b1));

    // R7
    p_swclr_count_r7: assert property (@(posedge clk) disable iff (rst)
        sw_clr |=> count == '0);

    p_swclr_div_r7: assert property (@(posedge clk) disable iff (rst)
        (sw_clr && div_sel != '0) |=> zero_flag);

    p_swclr_nodiv_r7: assert property (@(posedge clk) disable iff (rst)
        (sw_clr && div_sel == '0 && !zero_flag) |=> !zero_flag);

    // R8
    p_zero_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (zero_flag && !zero_ack) |=> zero_flag);

    p_cmp_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (cmp_flag && !cmp_ack) |=> cmp_flag);

    // R9
    p_irq_zero_en_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_zero) |-> zero_ie);

    p_irq_cmp_en_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_cmp) |-> cmp_ie);
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .div_sel   (div_sel),
    .sw_clr    (sw_clr),
    .zero_ack  (zero_ack),
    .cmp_ack   (cmp_ack),
    .zero_ie   (zero_ie),
    .cmp_ie    (cmp_ie),
    .count     (count),
    .zero_flag (zero_flag),
    .cmp_flag  (cmp_flag),
    .irq_zero  (irq_zero),
    .irq_cmp   (irq_cmp)
);

// File: tb/evt_timer_bench.sv
`timescale 1ns/1ps
module evt_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic [1:0]  div_sel = '0;
    logic        updown = 1'b0;
    logic [15:0] cmp_val = 16'd2;
    logic [2:0]  skip_n = '0;
    logic        sw_clr = 1'b0;
    logic        zero_ack = 1'b0;
    logic        cmp_ack = 1'b0;
    logic        zero_ie = 1'b0;
    logic        cmp_ie = 1'b0;
    logic [15:0] count;
    logic        zero_flag, cmp_flag, irq_zero, irq_cmp;

    int total = 0;
    int failed = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    evt_timer u_evt_timer (
        .clk(clk), .rst(rst), .run_en(run_en), .div_sel(div_sel),
        .updown(updown), .cmp_val(cmp_val), .skip_n(skip_n),
        .sw_clr(sw_clr), .zero_ack(zero_ack), .cmp_ack(cmp_ack),
        .zero_ie(zero_ie), .cmp_ie(cmp_ie), .count(count),
        .zero_flag(zero_flag), .cmp_flag(cmp_flag),
        .irq_zero(irq_zero), .irq_cmp(irq_cmp)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reset with a configuration, leave running from the next edge
    task automatic start(input bit ud, input int c, input int s, input int k);
        @(negedge clk);
        rst = 1'b1; run_en = 1'b0; sw_clr = 1'b0;
        zero_ack = 1'b0; cmp_ack = 1'b0;
        updown = ud; cmp_val = 16'(c); skip_n = 3'(s); div_sel = 2'(k);
        @(negedge clk);
        rst = 1'b0; run_en = 1'b1;
    endtask

    function automatic int exp_count(bit ud, int c, int t);
        int p;
        if (!ud) return t % (c + 1);
        p = t % (2 * c);
        return (p <= c) ? p : 2 * c - p;
    endfunction

    // R2 R3 R4 R5 sweep
    task automatic sweep(input bit ud, input int c, input int s, input int k, input int ncyc);
        int nz = 0;
        int nc = 0;
        int bad = 0;
        int bad_act = 0;
        int bad_exp = 0;
        int t = 0;
        int ez, ec;
        start(ud, c, s, k);
        for (int i = 1; i <= ncyc; i++) begin
            @(negedge clk);
            t = i >> k;
            if (int'(count) != exp_count(ud, c, t) && bad == 0) begin
                bad = 1; bad_act = int'(count); bad_exp = exp_count(ud, c, t);
            end
            if (zero_flag) nz++;
            if (cmp_flag) nc++;
            zero_ack = zero_flag;
            cmp_ack  = cmp_flag;
        end
        check($sformatf("R2/R3/R4 trajectory ud=%0d c=%0d k=%0d", ud, c, k), bad_act, bad_exp);
        if (!ud) begin
            ec = t / (c + 1);
            ez = ec;
            check($sformatf("R5 R3 thinned cmp ud=0 c=%0d s=%0d k=%0d", c, s, k), nc, ec / (s + 1));
            check($sformatf("R3 zero every reload c=%0d s=%0d k=%0d", c, s, k), nz, ez);
        end else begin
            ec = (t + c) / (2 * c);
            ez = t / (2 * c);
            check($sformatf("R5 R4 thinned zero ud=1 c=%0d s=%0d k=%0d", c, s, k), nz, ez / (s + 1));
            check($sformatf("R4 cmp every turn c=%0d s=%0d k=%0d", c, s, k), nc, ec);
        end
        @(negedge clk);
        zero_ack = 1'b0; cmp_ack = 1'b0;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int held;
        // R1 reset state after flags were set
        start(1'b0, 2, 0, 0);
        wait_neg(3);
        check("R3 flags set before reset", int'(zero_flag) + int'(cmp_flag), 2);
        rst = 1'b1;
        @(negedge clk);
        check("R1 count after reset", int'(count), 0);
        check("R1 flags after reset", int'(zero_flag) + int'(cmp_flag), 0);
        check("R1 irqs after reset", int'(irq_zero) + int'(irq_cmp), 0);

        // R2 hold with run_en low
        start(1'b0, 100, 0, 0);
        wait_neg(7);
        check("R2 count after 7 edges", int'(count), 7);
        run_en = 1'b0;
        held = int'(count);
        wait_neg(5);
        check("R2 count held", int'(count), held);

        // R7 clear on undivided tick: no zero flag
        start(1'b0, 100, 0, 0);
        wait_neg(10);
        sw_clr = 1'b1;
        @(negedge clk);
        sw_clr = 1'b0;
        check("R7 count cleared k=0", int'(count), 0);
        check("R7 no zero flag k=0", int'(zero_flag), 0);
        @(negedge clk);
        check("R7 count resumes k=0", int'(count), 1);

        // R7 clear on divided tick: zero flag set
        start(1'b0, 100, 0, 1);
        wait_neg(10);
        check("R2 count k=1 after 10 edges", int'(count), 5);
        sw_clr = 1'b1;
        @(negedge clk);
        sw_clr = 1'b0; run_en = 1'b0;
        check("R7 count cleared k=1", int'(count), 0);
        check("R7 zero flag k=1", int'(zero_flag), 1);

        // R9 gating, R8 stickiness
        check("R9 irq low while disabled", int'(irq_zero), 0);
        zero_ie = 1'b1;
        #1;
        check("R9 irq high when enabled", int'(irq_zero), 1);
        wait_neg(20);
        check("R8 flag sticky", int'(zero_flag), 1);
        zero_ack = 1'b1;
        @(negedge clk);
        zero_ack = 1'b0;
        check("R8 flag acked", int'(zero_flag), 0);
        check("R9 irq follows flag", int'(irq_zero), 0);
        zero_ie = 1'b0;

        // R8 set wins over ack at the same edge
        start(1'b0, 3, 0, 0);
        cmp_ack = 1'b1;
        wait_neg(4);
        check("R8 set beats ack", int'(cmp_flag), 1);
        @(negedge clk);
        check("R8 ack clears next edge", int'(cmp_flag), 0);
        cmp_ack = 1'b0;

        // R6 skip counter cleared by software clear
        start(1'b0, 2, 1, 0);
        wait_neg(3);
        check("R5 first event masked", int'(cmp_flag), 0);
        sw_clr = 1'b1;
        @(negedge clk);
        sw_clr = 1'b0;
        wait_neg(3);
        check("R6 event after clear still masked", int'(cmp_flag), 0);
        wait_neg(3);
        check("R6 second event after clear flags", int'(cmp_flag), 1);

        // R6 skip counter cleared by skip_n change
        start(1'b0, 2, 1, 0);
        wait_neg(3);
        skip_n = 3'd2;
        wait_neg(6);
        check("R6 masked after skip change", int'(cmp_flag), 0);
        wait_neg(3);
        check("R6 third event after change flags", int'(cmp_flag), 1);

        // exhaustive skip sweep
        for (int ud = 0; ud < 2; ud++)
            for (int ci = 0; ci < 2; ci++)
                for (int k = 0; k < 4; k += 2)
                    for (int s = 0; s < 8; s++)
                        sweep(ud[0], (ci == 0) ? 2 : 5, s, k, 800);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            failed++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule